// File: doc/BRIEF.md
# Floating-Point Condition Flag and Predicate Unit

This block classifies an 80-bit extended-precision value, made of a 16-bit sign/exponent word and a 64-bit mantissa with an explicit integer bit, into four condition flags: negative, zero, infinity and not-a-number. The flags sit in a small status register that is rewritten as a whole on a load strobe. Before classification the value can pass unchanged, have its sign cleared (absolute value) or have its sign inverted (negate). The possibly modified value is driven out for write-back.

The same unit answers conditional-branch style questions. A 5-bit predicate code is evaluated against the stored flags, and a single true/false answer comes out. NaN is treated as unordered. The upper sixteen codes behave exactly like the lower sixteen. Codes the unit does not implement raise an error output. For a compare, the caller supplies the difference (destination minus source) on the value port. For a test, the caller supplies the source itself. Both use the pass-through operation, because the arithmetic lives elsewhere.

Top module: `fpcc_unit`

## Requirements
- R1: While `rst_n` is low, all four flag outputs are 0.
- R2: On a cycle with `ld_en` high, the negative flag takes bit 15 of the result sign/exponent word (`res_se`).
- R3: The zero flag is loaded as 1 exactly when exponent bits 14..0 of the result are all 0 and mantissa bits 62..0 are all 0. Mantissa bit 63 has no effect on this flag.
- R4: The infinity flag is loaded as 1 exactly when the result exponent is 0x7FFF and mantissa bits 62..0 are all 0. Mantissa bit 63 has no effect on this flag.
- R5: The NaN flag is loaded as 1 exactly when the result exponent is 0x7FFF and mantissa bits 62..0 are not all 0.
- R6: A load replaces all four flags, so no earlier flag survives it. Without `ld_en`, the flags hold whatever changes on the value inputs.
- R7: `op_sel` selects how the value is changed before it is driven on `res_se`/`res_man` and classified. The encodings are: 0 = test (pass through), 1 = absolute value (bit 15 cleared), 2 = negate (bit 15 inverted), 3 = compare difference (pass through). The mantissa always passes unchanged.
- R8: For predicate codes 0x00–0x0F, `pred_true` follows this table. 0: false. 1: Z. 2: not (NaN or Z or N). 3: Z or not (NaN or N). 4: N and not (NaN or Z). 5: Z or (N and not NaN). A: NaN or not (N or Z). B: NaN or Z or not N. C: NaN or (N and not Z). D: NaN or Z or N. E: not Z. F: true.
- R9: Predicate codes 0x10–0x1F give the same `pred_true` and `pred_bad` as the code with bit 4 cleared.
- R10: Codes 0x06–0x09 and 0x16–0x19 drive `pred_bad` high and `pred_true` low. Every other code drives `pred_bad` low.
- R11: The predicate is evaluated combinationally from the registered flags. In the cycle of a load it still reflects the old flags, and from the next cycle on it reflects the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe for the flag register |
| op_sel | input | 2 | Sign operation: 0 test, 1 abs, 2 negate, 3 compare difference |
| src_se | input | 16 | Sign (bit 15) and exponent (bits 14..0) of the input value |
| src_man | input | 64 | Mantissa of the input value, bit 63 is the integer bit |
| res_se | output | 16 | Sign/exponent word after the sign operation |
| res_man | output | 64 | Mantissa of the result (unchanged) |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_i | output | 1 | Stored infinity flag |
| flag_nan | output | 1 | Stored not-a-number flag |
| pred_code | input | 5 | Predicate code |
| pred_true | output | 1 | Predicate result |
| pred_bad | output | 1 | Unsupported predicate code |

## Verification
A flag load and a predicate evaluation can fall in the same cycle. In that cycle a branch asks about the flags just as a new value is being classified. The bench provokes this by driving `ld_en` with a new value and a flag-sensitive predicate code at the same time. It judges that `pred_true` still gives the old answer before the clock edge and the new answer after it. The main sweep crosses corner exponents, signs, mantissa patterns and all four operations, and then evaluates all 32 predicate codes against each resulting flag state.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic inf;
    logic nan;
  } fpcc_flags_t;

  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_ABS  = 2'b01,
    OP_NEG  = 2'b10,
    OP_CMPD = 2'b11
  } fpcc_op_e;
endpackage

// File: rtl/fpcc_signop.sv
module fpcc_signop #(
  parameter int EXP_W = 15
) (
  input  logic [1:0]     op_sel,
  input  logic [EXP_W:0] in_se,
  output logic [EXP_W:0] out_se
);
  import fpcc_pkg::*;

  fpcc_op_e op;

  always_comb begin
    op     = fpcc_op_e'(op_sel);
    out_se = in_se;
    unique case (op)
      OP_ABS:  out_se[EXP_W] = 1'b0;
      OP_NEG:  out_se[EXP_W] = ~in_se[EXP_W];
      default: out_se = in_se;
    endcase
  end
endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W:0]   val_se,
  input  logic [MAN_W-1:0] val_man,
  output fpcc_pkg::fpcc_flags_t cls
);
  localparam int FRAC_W = MAN_W - 1;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_min, exp_max, frac_nil;

  always_comb begin
    expo     = val_se[EXP_W-1:0];
    frac     = val_man[FRAC_W-1:0];
    exp_min  = ~|expo;
    exp_max  = &expo;
    frac_nil = ~|frac;
    cls.n    = val_se[EXP_W];
    cls.z    = exp_min & frac_nil;
    cls.inf  = exp_max & frac_nil;
    cls.nan  = exp_max & ~frac_nil;
  end
endmodule

// File: rtl/fpcc_pred.sv
module fpcc_pred #(
  parameter int CODE_W = 5
) (
  input  logic [CODE_W-1:0]     code,
  input  fpcc_pkg::fpcc_flags_t fl,
  output logic                  hit,
  output logic                  bad
);
  localparam int SEL_W = 4;

  logic [SEL_W-1:0] sel;
  logic n, z, u;

  always_comb begin
    sel = code[SEL_W-1:0];
    n   = fl.n;
    z   = fl.z;
    u   = fl.nan;
    hit = 1'b0;
    bad = 1'b0;
    unique case (sel)
      4'h0: hit = 1'b0;
      4'h1: hit = z;
      4'h2: hit = ~(u | z | n);
      4'h3: hit = z | ~(u | n);
      4'h4: hit = n & ~(u | z);
      4'h5: hit = z | (n & ~u);
      4'hA: hit = u | ~(n | z);
      4'hB: hit = u | z | ~n;
      4'hC: hit = u | (n & ~z);
      4'hD: hit = u | z | n;
      4'hE: hit = ~z;
      4'hF: hit = 1'b1;
      default: begin
        hit = 1'b0;
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit #(
  parameter int EXP_W  = 15,
  parameter int MAN_W  = 64,
  parameter int CODE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [1:0]         op_sel,
  input  logic [EXP_W:0]     src_se,
  input  logic [MAN_W-1:0]   src_man,
  output logic [EXP_W:0]     res_se,
  output logic [MAN_W-1:0]   res_man,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_i,
  output logic               flag_nan,
  input  logic [CODE_W-1:0]  pred_code,
  output logic               pred_true,
  output logic               pred_bad
);
  import fpcc_pkg::*;

  fpcc_flags_t cls_w;
  fpcc_flags_t flags_d;
  fpcc_flags_t flags_q;

  fpcc_signop #(.EXP_W(EXP_W)) u_sign (
    .op_sel (op_sel),
    .in_se  (src_se),
    .out_se (res_se)
  );

  assign res_man = src_man;

  fpcc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .val_se  (res_se),
    .val_man (res_man),
    .cls     (cls_w)
  );

  always_comb begin
    flags_d = flags_q;
    if (ld_en) flags_d = cls_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flag_n   = flags_q.n;
  assign flag_z   = flags_q.z;
  assign flag_i   = flags_q.inf;
  assign flag_nan = flags_q.nan;

  fpcc_pred #(.CODE_W(CODE_W)) u_pred (
    .code (pred_code),
    .fl   (flags_q),
    .hit  (pred_true),
    .bad  (pred_bad)
  );
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk #(
  parameter int EXP_W  = 15,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic [1:0]        op_sel,
  input logic [EXP_W:0]    res_se,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_i,
  input logic              flag_nan,
  input logic [CODE_W-1:0] pred_code,
  input logic              pred_true,
  input logic              pred_bad
);
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable({flag_n, flag_z, flag_i, flag_nan})); // R6

  AST_NEG_FROM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> flag_n == $past(res_se[EXP_W])); // R2

  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_z, flag_i, flag_nan})); // R5

  AST_ABS_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01) |-> !res_se[EXP_W]); // R7

  AST_BAD_IS_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_bad |-> !pred_true); // R10

  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_code[3:0] == 4'hF) |-> (pred_true && !pred_bad)); // R8
endmodule

bind fpcc_unit fpcc_unit_chk #(.EXP_W(EXP_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_en     (ld_en),
  .op_sel    (op_sel),
  .res_se    (res_se),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_i    (flag_i),
  .flag_nan  (flag_nan),
  .pred_code (pred_code),
  .pred_true (pred_true),
  .pred_bad  (pred_bad)
);

// File: tb/sim_fpcc_unit.sv
`timescale 1ns/1ps
module sim_fpcc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  op_sel;
  logic [15:0] src_se;
  logic [63:0] src_man;
  logic [15:0] res_se;
  logic [63:0] res_man;
  logic        flag_n, flag_z, flag_i, flag_nan;
  logic [4:0]  pred_code;
  logic        pred_true, pred_bad;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fpcc_unit u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .op_sel(op_sel),
    .src_se(src_se), .src_man(src_man), .res_se(res_se), .res_man(res_man),
    .flag_n(flag_n), .flag_z(flag_z), .flag_i(flag_i), .flag_nan(flag_nan),
    .pred_code(pred_code), .pred_true(pred_true), .pred_bad(pred_bad)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Expected predicate from the requirement table; returns {bad, true}
  function automatic logic [1:0] pred_model(input int code, input logic n, z, u);
    int c = code % 16;
    logic lt = n && !u && !z;
    logic eq = z;
    logic gt = !n && !u && !z;
    if (c >= 6 && c <= 9) return 2'b10;
    case (c)
      0:  return 2'b00;
      1:  return {1'b0, eq};
      2:  return {1'b0, gt};
      3:  return {1'b0, gt || eq};
      4:  return {1'b0, lt};
      5:  return {1'b0, lt || eq};
      10: return {1'b0, u || gt};
      11: return {1'b0, u || gt || eq};
      12: return {1'b0, u || lt};
      13: return {1'b0, u || lt || eq};
      14: return {1'b0, !eq};
      default: return 2'b01;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [14:0] exps [5];
    logic [63:0] mans [6];
    exps[0] = 15'h0000; exps[1] = 15'h0001; exps[2] = 15'h3FFF;
    exps[3] = 15'h7FFE; exps[4] = 15'h7FFF;
    mans[0] = 64'h0; mans[1] = 64'h8000_0000_0000_0000;
    mans[2] = 64'h1; mans[3] = 64'h4000_0000_0000_0000;
    mans[4] = 64'h8000_0000_0000_0001; mans[5] = '1;

    rst_n = 1'b0; ld_en = 1'b0; op_sel = 2'd0;
    src_se = 16'hFFFF; src_man = 64'h0; pred_code = 5'd0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flags in reset", {flag_n, flag_z, flag_i, flag_nan}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 flags after reset", {flag_n, flag_z, flag_i, flag_nan}, 4'b0000);

    for (int ei = 0; ei < 5; ei++)
      for (int s = 0; s < 2; s++)
        for (int mi = 0; mi < 6; mi++)
          for (int op = 0; op < 4; op++) begin
            logic [15:0] ese;
            logic [14:0] ex;
            logic [62:0] fr;
            logic en, ez, ei2, eu;
            @(negedge clk);
            src_se  = {s[0], exps[ei]};
            src_man = mans[mi];
            op_sel  = op[1:0];
            ld_en   = 1'b1;
            ese = src_se;
            if (op == 1) ese[15] = 1'b0;
            if (op == 2) ese[15] = ~src_se[15];
            #1;
            chk("R7 res_se", res_se, ese);
            chk("R7 res_man", res_man, src_man);
            @(negedge clk);
            ld_en = 1'b0;
            ex = ese[14:0];
            fr = mans[mi][62:0];
            en = ese[15];
            ez = (ex == 15'h0) && (fr == 63'h0);
            ei2 = (ex == 15'h7FFF) && (fr == 63'h0);
            eu = (ex == 15'h7FFF) && (fr != 63'h0);
            #1;
            chk("R2 flag_n", flag_n, en);
            chk("R3 flag_z", flag_z, ez);
            chk("R4 flag_i", flag_i, ei2);
            chk("R5 flag_nan", flag_nan, eu);
            for (int pc = 0; pc < 32; pc++) begin
              logic [1:0] e;
              pred_code = pc[4:0];
              #1;
              e = pred_model(pc, en, ez, eu);
              if (pc % 16 >= 6 && pc % 16 <= 9)
                chk("R10 unsupported", {pred_bad, pred_true}, e);
              else if (pc >= 16)
                chk("R9 alias", {pred_bad, pred_true}, e);
              else
                chk("R8 table", {pred_bad, pred_true}, e);
            end
          end

    // R6: load NaN, then change inputs without ld_en; flags hold
    @(negedge clk);
    src_se = 16'hFFFF; src_man = 64'h0000_0000_0000_0001; op_sel = 2'd0; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0; src_se = 16'h0000; src_man = 64'h0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R6 hold without load", {flag_n, flag_z, flag_i, flag_nan}, 4'b1001);
    // R6: next load replaces every flag (stale NaN/N cleared)
    ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    #1;
    chk("R6 full replace", {flag_n, flag_z, flag_i, flag_nan}, 4'b0100);

    // R11: load and predicate in same cycle; flags currently Z=1
    @(negedge clk);
    src_se = 16'h3FFF; src_man = 64'h8000_0000_0000_0000; op_sel = 2'd3;
    ld_en = 1'b1; pred_code = 5'h01;
    #1;
    chk("R11 old flags before edge", pred_true, 1'b1);
    @(posedge clk);
    #1;
    chk("R11 new flags after edge", pred_true, 1'b0);
    chk("R11 not-equal after edge", {pred_bad, 1'b0}, 2'b00);
    @(negedge clk);
    ld_en = 1'b0;
    #1;
    pred_code = 5'h0E;
    #1;
    chk("R11 ne true next cycle", pred_true, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule